// File: doc/BRIEF.md
# NAND Page Program and Erase Engine

This block is a small on-chip model of a NAND storage array built from pages, each followed by a spare area, and it sits behind a command front end. The front end issues four request types: start a buffer fill, load a page for readout, program a page, and erase a block. Data enters through a streaming write port that appends bus-width beats to a fill buffer. Data leaves through a streaming read port that walks the loaded page from a chosen column.

The array behaves like real NAND cells. A program can only clear bits, because the buffered bytes are ANDed into what is already stored. An erase sets every byte of a whole block back to all ones. The array size, page size and pages per block are parameters. The spare area of each page is one thirty-second of the page size. The bus is one or two bytes wide.

Top module: `nand_pgm_engine`

## Requirements
- R1: After reset every byte of every page and spare area reads 0xFF, `rd_avail` is 0, `done` is 0 and `dout` is 0.
- R2: The spare area holds PAGE_BYTES/32 bytes. A load (`cmd_op`=1) of a valid page at column c sets `rd_avail` to L-c, where L is page plus spare when `spare_en`=1 and the page size alone when `spare_en`=0.
- R3: A program (`cmd_op`=2) ANDs each buffered byte into the addressed page. The first byte goes to the column latched by the last start-fill request, so a stored bit can only go from 1 to 0.
- R4: A start-fill request (`cmd_op`=0) empties the buffer. Each `din_valid` beat then appends BUS_BYTES bytes, low byte first. Bytes beyond page plus spare length are discarded and never wrap.
- R5: Every program request returns the program column to 0, so a second program that has no start-fill first writes the same buffer from column 0.
- R6: An erase (`cmd_op`=3) clears the low page-index bits to the block boundary and sets every byte of every page and spare area in that block to 0xFF. Other blocks are left unchanged.
- R7: While `wp_n` is low, programs and erases leave the array unchanged.
- R8: A program or erase whose page index is at or beyond NUM_PAGES changes nothing. A load of such a page, or a load whose column is beyond L, gives `rd_avail`=0.
- R9: A read request returns, one cycle later on `dout`, the byte at the read pointer in bits 7:0 and the next byte in bits 15:8. The pointer then advances by BUS_BYTES and `rd_avail` drops by BUS_BYTES, stopping at 0.
- R10: A read request made while `rd_avail` is 0 drives `dout` to 0 and leaves the pointer and `rd_avail` unchanged.
- R11: `done` is high for exactly the one cycle after each program or erase request, whether the request was carried out or suppressed. It is never high after a load or start-fill request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write protect, low blocks program and erase |
| spare_en | input | 1 | Include spare bytes in load length |
| cmd_valid | input | 1 | Request strobe, one cycle |
| cmd_op | input | 2 | 0 start fill, 1 load, 2 program, 3 erase |
| cmd_page | input | PAGE_AW (5) | Page index of the request |
| cmd_col | input | COL_W (7) | Column for load or start fill |
| din_valid | input | 1 | Fill beat strobe |
| din | input | 8*BUS_BYTES (16) | Fill data, low byte first |
| rd_req | input | 1 | Read beat request |
| dout | output | 8*BUS_BYTES (16) | Read data, valid the cycle after rd_req |
| rd_avail | output | COL_W (7) | Bytes still readable from the loaded page |
| done | output | 1 | Program or erase completion pulse |

## Verification
Any fault in the array, in the program mask or in the erase decode stays hidden until a later load and read of the page it touched. For that reason every program and erase scenario ends with a load and readback of the target page, and of a neighbour page that must not change. Pointer and length faults show on `rd_avail` in the cycle right after a load or read beat, and in the order of words on `dout`. Buffer overrun faults are reached by overfilling with a distinct last word and then reading both the first and the final columns.

// File: rtl/nand_pe_pkg.sv
package nand_pe_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_LOAD  = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } nand_op_e;
endpackage

// File: rtl/nand_fill_buf.sv
// Page fill buffer: appends bus beats low byte first, capped at row length.
module nand_fill_buf #(
  parameter int ROW       = 66,
  parameter int COL_W     = 7,
  parameter int BUS_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   push,
  input  logic [8*BUS_BYTES-1:0] din,
  output logic [8*ROW-1:0]       buf_flat,
  output logic [COL_W-1:0]       cnt
);
  logic [7:0]       data_q [ROW];
  logic [7:0]       data_d [ROW];
  logic [COL_W-1:0] cnt_q, cnt_d;

  always_comb begin
    data_d = data_q;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (push) begin
      for (int k = 0; k < BUS_BYTES; k++) begin
        if (int'(cnt_d) < ROW) begin
          data_d[int'(cnt_d)] = din[k*8 +: 8];
          cnt_d = cnt_d + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr || push) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (push && !clr) data_q <= data_d;
  end

  for (genvar i = 0; i < ROW; i++) begin : g_flat
    assign buf_flat[i*8 +: 8] = data_q[i];
  end
  assign cnt = cnt_q;
endmodule

// File: rtl/nand_store.sv
// Page array: AND-program, block erase to ones, combinational bus read.
module nand_store #(
  parameter int NUM_PAGES     = 16,
  parameter int ROW           = 66,
  parameter int PAGES_PER_BLK = 4,
  parameter int PAGE_AW       = 5,
  parameter int COL_W         = 7,
  parameter int BUS_BYTES     = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prog_en,
  input  logic [PAGE_AW-1:0]     prog_page,
  input  logic [COL_W-1:0]       prog_col,
  input  logic [COL_W-1:0]       prog_cnt,
  input  logic [8*ROW-1:0]       prog_data,
  input  logic                   erase_en,
  input  logic [PAGE_AW-1:0]     erase_page,
  input  logic [PAGE_AW-1:0]     rd_page,
  input  logic [COL_W-1:0]       rd_col,
  output logic [8*BUS_BYTES-1:0] rd_data
);
  localparam logic [PAGE_AW-1:0] BLK_MASK = PAGE_AW'(PAGES_PER_BLK - 1);

  logic [7:0]         mem_q [NUM_PAGES][ROW];
  logic [7:0]         mem_d [NUM_PAGES][ROW];
  logic [PAGE_AW-1:0] blk_base;
  logic               wr_en;

  assign blk_base = erase_page & ~BLK_MASK;
  assign wr_en    = prog_en | erase_en;

  always_comb begin
    mem_d = mem_q;
    for (int p = 0; p < NUM_PAGES; p++) begin
      for (int b = 0; b < ROW; b++) begin
        if (erase_en && p >= int'(blk_base) && p < int'(blk_base) + PAGES_PER_BLK) begin
          mem_d[p][b] = 8'hFF;
        end else if (prog_en && p == int'(prog_page)) begin
          if (b >= int'(prog_col) && (b - int'(prog_col)) < int'(prog_cnt))
            mem_d[p][b] = mem_q[p][b] & prog_data[(b - int'(prog_col))*8 +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PAGES; p++)
        for (int b = 0; b < ROW; b++)
          mem_q[p][b] <= 8'hFF;
    end else if (wr_en) begin
      mem_q <= mem_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < BUS_BYTES; k++) begin
      if (int'(rd_page) < NUM_PAGES && int'(rd_col) + k < ROW)
        rd_data[k*8 +: 8] = mem_q[int'(rd_page)][int'(rd_col) + k];
    end
  end
endmodule

// File: rtl/nand_rd_port.sv
// Read pointer, remaining length and registered read data.
module nand_rd_port #(
  parameter int COL_W     = 7,
  parameter int BUS_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [COL_W-1:0]       load_col,
  input  logic [COL_W-1:0]       load_len,
  input  logic                   rd_req,
  input  logic [8*BUS_BYTES-1:0] rd_data,
  output logic [COL_W-1:0]       ptr,
  output logic [COL_W-1:0]       avail,
  output logic [8*BUS_BYTES-1:0] dout
);
  localparam logic [COL_W-1:0] STEP = COL_W'(BUS_BYTES);

  logic [COL_W-1:0]       ptr_q, ptr_d, avail_q, avail_d;
  logic [8*BUS_BYTES-1:0] dout_q, dout_d;
  logic                   en;

  assign en = load | rd_req;

  always_comb begin
    ptr_d   = ptr_q;
    avail_d = avail_q;
    dout_d  = dout_q;
    if (load) begin
      ptr_d   = load_col;
      avail_d = load_len;
    end else if (rd_req) begin
      if (avail_q != '0) begin
        dout_d  = rd_data;
        ptr_d   = ptr_q + STEP;
        avail_d = (avail_q > STEP) ? avail_q - STEP : '0;
      end else begin
        dout_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      avail_q <= '0;
      dout_q  <= '0;
    end else if (en) begin
      ptr_q   <= ptr_d;
      avail_q <= avail_d;
      dout_q  <= dout_d;
    end
  end

  assign ptr   = ptr_q;
  assign avail = avail_q;
  assign dout  = dout_q;
endmodule

// File: rtl/nand_pgm_engine.sv
// Top: request decode, protection and range gating, program column, done pulse.
module nand_pgm_engine #(
  parameter int PAGE_BYTES    = 64,
  parameter int NUM_PAGES     = 16,
  parameter int PAGES_PER_BLK = 4,
  parameter int BUS_BYTES     = 2,
  localparam int SPARE        = PAGE_BYTES / 32,
  localparam int ROW          = PAGE_BYTES + SPARE,
  localparam int COL_W        = $clog2(ROW + 1),
  localparam int PAGE_AW      = $clog2(NUM_PAGES) + 1,
  localparam int DW           = 8 * BUS_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wp_n,
  input  logic               spare_en,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [PAGE_AW-1:0] cmd_page,
  input  logic [COL_W-1:0]   cmd_col,
  input  logic               din_valid,
  input  logic [DW-1:0]      din,
  input  logic               rd_req,
  output logic [DW-1:0]      dout,
  output logic [COL_W-1:0]   rd_avail,
  output logic               done
);
  import nand_pe_pkg::*;

  logic               is_start, is_load, is_prog, is_erase, page_ok;
  logic [COL_W-1:0]   col_q, col_d, len, load_len, buf_cnt, rd_ptr;
  logic [PAGE_AW-1:0] rd_page_q, rd_page_d;
  logic               done_q, done_d;
  logic [8*ROW-1:0]   buf_flat;
  logic [DW-1:0]      rd_data;

  assign is_start = cmd_valid && cmd_op == OP_START;
  assign is_load  = cmd_valid && cmd_op == OP_LOAD;
  assign is_prog  = cmd_valid && cmd_op == OP_PROG;
  assign is_erase = cmd_valid && cmd_op == OP_ERASE;
  assign page_ok  = int'(cmd_page) < NUM_PAGES;

  assign len      = spare_en ? COL_W'(ROW) : COL_W'(PAGE_BYTES);
  assign load_len = (page_ok && cmd_col <= len) ? len - cmd_col : '0;

  always_comb begin
    col_d     = col_q;
    rd_page_d = rd_page_q;
    done_d    = is_prog || is_erase;
    if (is_start)     col_d = cmd_col;
    else if (is_prog) col_d = '0;
    if (is_load) rd_page_d = cmd_page;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q     <= '0;
      rd_page_q <= '0;
      done_q    <= 1'b0;
    end else begin
      if (is_start || is_prog) col_q <= col_d;
      if (is_load) rd_page_q <= rd_page_d;
      done_q <= done_d;
    end
  end

  nand_fill_buf #(.ROW(ROW), .COL_W(COL_W), .BUS_BYTES(BUS_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(is_start), .push(din_valid),
    .din(din), .buf_flat(buf_flat), .cnt(buf_cnt)
  );

  nand_store #(
    .NUM_PAGES(NUM_PAGES), .ROW(ROW), .PAGES_PER_BLK(PAGES_PER_BLK),
    .PAGE_AW(PAGE_AW), .COL_W(COL_W), .BUS_BYTES(BUS_BYTES)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .prog_en(is_prog && wp_n && page_ok), .prog_page(cmd_page),
    .prog_col(col_q), .prog_cnt(buf_cnt), .prog_data(buf_flat),
    .erase_en(is_erase && wp_n && page_ok), .erase_page(cmd_page),
    .rd_page(rd_page_q), .rd_col(rd_ptr), .rd_data(rd_data)
  );

  nand_rd_port #(.COL_W(COL_W), .BUS_BYTES(BUS_BYTES)) u_rd (
    .clk(clk), .rst_n(rst_n), .load(is_load), .load_col(cmd_col),
    .load_len(load_len), .rd_req(rd_req), .rd_data(rd_data),
    .ptr(rd_ptr), .avail(rd_avail), .dout(dout)
  );

  assign done = done_q;
endmodule

// File: rtl/nand_pgm_engine_chk.sv
module nand_pgm_engine_chk #(
  parameter int ROW       = 66,
  parameter int NUM_PAGES = 16,
  parameter int COL_W     = 7,
  parameter int PAGE_AW   = 5,
  parameter int BUS_BYTES = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic [1:0]             cmd_op,
  input logic [PAGE_AW-1:0]     cmd_page,
  input logic                   rd_req,
  input logic [COL_W-1:0]       rd_avail,
  input logic [8*BUS_BYTES-1:0] dout,
  input logic                   done
);
  // R11: completion pulse follows every program or erase request
  p_done_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op[1]) |=> done);

  // R11: no pulse without a program or erase request
  p_done_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_op[1]) |=> !done);

  // R8: out-of-range load exposes nothing
  p_load_oob_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1 && int'(cmd_page) >= NUM_PAGES) |=> rd_avail == '0);

  // R9: each beat consumes one bus width
  p_read_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !(cmd_valid && cmd_op == 2'd1) && int'(rd_avail) > BUS_BYTES)
    |=> rd_avail == $past(rd_avail) - COL_W'(BUS_BYTES));

  // R10: read with nothing left returns zero and keeps length at zero
  p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !(cmd_valid && cmd_op == 2'd1) && rd_avail == '0)
    |=> (dout == '0 && rd_avail == '0));

  // R2: length never exceeds page plus spare
  always_comb begin
    if (rst_n) p_avail_cap_r2: assert (int'(rd_avail) <= ROW);
  end
endmodule

bind nand_pgm_engine nand_pgm_engine_chk #(
  .ROW(ROW), .NUM_PAGES(NUM_PAGES), .COL_W(COL_W),
  .PAGE_AW(PAGE_AW), .BUS_BYTES(BUS_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_page(cmd_page), .rd_req(rd_req), .rd_avail(rd_avail),
  .dout(dout), .done(done)
);

// File: tb/nand_pgm_engine_tb.sv
module nand_pgm_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_n = 1'b1;
  logic        spare_en = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [4:0]  cmd_page = '0;
  logic [6:0]  cmd_col = '0;
  logic        din_valid = 1'b0;
  logic [15:0] din = '0;
  logic        rd_req = 1'b0;
  logic [15:0] dout;
  logic [6:0]  rd_avail;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  nand_pgm_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .spare_en(spare_en),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_page(cmd_page),
    .cmd_col(cmd_col), .din_valid(din_valid), .din(din),
    .rd_req(rd_req), .dout(dout), .rd_avail(rd_avail), .done(done)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input int page, input int col);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_page = 5'(page); cmd_col = 7'(col);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    din_valid = 1'b1; din = w;
    @(negedge clk);
    din_valid = 1'b0;
  endtask

  task automatic rd_word(input int exp, input string req);
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk(int'(dout), exp, req);
  endtask

  task automatic t_reset();
    chk(int'(rd_avail), 0, "R1 avail");
    chk(int'(done), 0, "R1 done");
    chk(int'(dout), 0, "R1 dout");
    issue(2'd1, 0, 0);
    chk(int'(done), 0, "R11 no pulse on load");
    chk(int'(rd_avail), 66, "R2 full length");
    rd_word(16'hFFFF, "R1 erased word");
    chk(int'(rd_avail), 64, "R9 step");
  endtask

  task automatic t_program();
    issue(2'd0, 0, 0);
    chk(int'(done), 0, "R11 no pulse on start");
    push(16'h1234); push(16'h5678);
    issue(2'd2, 3, 0);
    chk(int'(done), 1, "R11 pulse");
    @(negedge clk);
    chk(int'(done), 0, "R11 single cycle");
    issue(2'd1, 3, 0);
    rd_word(16'h1234, "R4 low first");
    rd_word(16'h5678, "R9 order");
    rd_word(16'hFFFF, "R3 rest untouched");
    issue(2'd0, 0, 0);
    push(16'hFF0F);
    issue(2'd2, 3, 0);
    issue(2'd1, 3, 0);
    rd_word(16'h1204, "R3 and");
    rd_word(16'h5678, "R3 neighbour");
  endtask

  task automatic t_column();
    issue(2'd0, 0, 4);
    push(16'h00F0);
    issue(2'd2, 5, 0);
    issue(2'd2, 5, 0);
    issue(2'd1, 5, 0);
    rd_word(16'h00F0, "R5 column zero");
    rd_word(16'hFFFF, "R3 gap");
    rd_word(16'h00F0, "R3 latched column");
  endtask

  task automatic t_cap();
    issue(2'd0, 0, 0);
    for (int i = 0; i < 33; i++) push(16'hAAAA);
    push(16'h0000);
    issue(2'd2, 6, 0);
    issue(2'd1, 6, 64);
    chk(int'(rd_avail), 2, "R2 spare tail");
    rd_word(16'hAAAA, "R4 overflow dropped");
    issue(2'd1, 6, 0);
    rd_word(16'hAAAA, "R4 no wrap");
  endtask

  task automatic t_erase();
    issue(2'd3, 7, 0);
    chk(int'(done), 1, "R11 erase pulse");
    issue(2'd1, 5, 0);
    rd_word(16'hFFFF, "R6 aligned erase");
    rd_word(16'hFFFF, "R6 aligned erase w1");
    issue(2'd1, 6, 64);
    rd_word(16'hFFFF, "R6 spare erased");
    issue(2'd1, 3, 0);
    rd_word(16'h1204, "R6 other block kept");
  endtask

  task automatic t_protect();
    wp_n = 1'b0;
    issue(2'd0, 0, 0);
    push(16'h0000);
    issue(2'd2, 3, 0);
    chk(int'(done), 1, "R7 pulse when blocked");
    issue(2'd3, 3, 0);
    chk(int'(done), 1, "R7 pulse when blocked erase");
    issue(2'd1, 3, 0);
    rd_word(16'h1204, "R7 protected");
    wp_n = 1'b1;
  endtask

  task automatic t_range();
    issue(2'd0, 0, 0);
    push(16'h0000);
    issue(2'd2, 16, 0);
    issue(2'd3, 16, 0);
    issue(2'd1, 0, 0);
    rd_word(16'hFFFF, "R8 program ignored");
    issue(2'd1, 3, 0);
    rd_word(16'h1204, "R8 erase ignored");
    issue(2'd1, 16, 0);
    chk(int'(rd_avail), 0, "R8 load page oob");
    issue(2'd1, 0, 67);
    chk(int'(rd_avail), 0, "R8 col past");
    issue(2'd1, 0, 66);
    chk(int'(rd_avail), 0, "R8 col at end");
    issue(2'd1, 0, 65);
    chk(int'(rd_avail), 1, "R2 one left");
    spare_en = 1'b0;
    issue(2'd1, 0, 0);
    chk(int'(rd_avail), 64, "R2 no spare");
    issue(2'd1, 0, 10);
    chk(int'(rd_avail), 54, "R2 minus column");
    spare_en = 1'b1;
  endtask

  task automatic t_past_end();
    issue(2'd1, 0, 64);
    rd_word(16'hFFFF, "R9 last word");
    chk(int'(rd_avail), 0, "R9 drained");
    rd_word(16'h0000, "R10 zero read");
    chk(int'(rd_avail), 0, "R10 avail held");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_column();
    t_cap();
    t_erase();
    t_protect();
    t_range();
    t_past_end();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule